// File: doc/BRIEF.md
# Interrupt Destination Bitmask Resolver

This block turns the addressing fields of an interrupt request into a bitmask of the processing units that should receive it. It holds a small table with one entry per unit. Each entry has a present flag, a physical ID byte, a logical address byte and a 4-bit addressing-model code. Software or boot logic fills the table through a write port.

A request carries a destination byte, a mode bit, a 2-bit shorthand code, the index of the sending unit and a lowest-priority flag. The block captures the request on a clock edge. It drives the resolved mask, with a valid strobe, during the following cycle.

For lowest-priority requests the block also names a single target: the lowest-numbered unit in the mask. Delivering the interrupt and arbitrating between units by priority are left to the logic downstream.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset, `res_valid` and `one_valid` are 0 and every table entry is absent, so any request resolves to an all-zero mask.
- R2: A request with `req_valid` high is captured at a clock edge. `res_valid` is high for exactly the following cycle, and `tgt_mask` in that cycle reflects the captured fields. Input changes after the capture edge do not alter the mask.
- R3: With `req_logical`=0 and shorthand 0, destination 0xFF selects every present unit.
- R4: With `req_logical`=0 and shorthand 0, any destination other than 0xFF selects every present unit whose physical ID equals it. If no unit matches, the mask is zero.
- R5: With `req_logical`=1 and shorthand 0, a unit whose model code is 0xF is selected when the bitwise AND of the destination and its logical byte is nonzero.
- R6: With `req_logical`=1 and shorthand 0, a unit whose model code is 0x0 is selected when two conditions hold: bits [7:4] of the destination equal bits [7:4] of its logical byte, and the AND of their bits [3:0] is nonzero.
- R7: In logical mode, a unit whose model code is neither 0xF nor 0x0 is never selected.
- R8: Shorthand 1 selects only the unit given by `req_self`, ignoring the destination and mode fields.
- R9: Shorthand 2 selects all present units. Shorthand 3 selects all present units except `req_self`.
- R10: A unit whose present flag is 0 is never set in `tgt_mask`, whatever the shorthand or mode.
- R11: When the captured request has `req_lowpri`=1 and the mask is nonzero, `one_valid` is high and `one_idx` is the lowest set bit of the mask. Otherwise `one_valid` is 0.
- R12: A table write (`tbl_we`) at a clock edge replaces entry `tbl_idx`. Requests resolved in later cycles use the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Table write enable |
| tbl_idx | input | IDX_W | Table entry to write |
| tbl_present | input | 1 | Present flag written |
| tbl_phys_id | input | 8 | Physical ID written |
| tbl_log_byte | input | 8 | Logical address byte written |
| tbl_model | input | 4 | Addressing-model code written (0xF flat, 0x0 cluster) |
| req_valid | input | 1 | Request strobe |
| req_dest | input | 8 | Destination byte |
| req_logical | input | 1 | 0 physical, 1 logical |
| req_short | input | 2 | Shorthand: 0 fields, 1 self, 2 all, 3 all but self |
| req_self | input | IDX_W | Index of the sending unit |
| req_lowpri | input | 1 | Lowest-priority delivery requested |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| tgt_mask | output | N_UNITS | Resolved target mask |
| one_valid | output | 1 | Single target valid |
| one_idx | output | IDX_W | Single lowest-priority target |

## Verification
The bench goes after the addressing corners that are easy to get wrong.

- **Duplicate physical IDs.** Two units share an ID. A design that stops at the first match would report only one of them.
- **Unknown model code.** One unit carries a model code that is neither flat nor cluster. A design that treats every non-cluster code as flat would select it.
- **Flat and cluster together.** One logical destination hits flat and cluster units at once. A missing nibble compare would pull in other clusters. A destination with zero member bits must select no cluster unit.
- **Shorthands and absent units.** Self and all-but-self are tried with the sender present and with it absent. A design that forgets the present flag would target empty table slots.
- **Lowest-priority pick.** The pick is tried on masks whose lowest bit is 0, 1 and 7, and on an empty mask. An encoder that picks the highest bit, or raises a valid flag on an empty mask, would be caught.

// File: rtl/irq_dest_pkg.sv
// Package: shared types and code values for the destination resolver.
// Assumes 8-bit destination bytes and 4-bit addressing-model codes.
package irq_dest_pkg;

    localparam logic [7:0] BCAST_ID      = 8'hFF;
    localparam logic [3:0] MODEL_FLAT    = 4'hF;
    localparam logic [3:0] MODEL_CLUSTER = 4'h0;

    typedef enum logic [1:0] {
        SH_FIELDS   = 2'd0,
        SH_SELF     = 2'd1,
        SH_ALL      = 2'd2,
        SH_ALL_BUT  = 2'd3
    } shorthand_e;

    typedef struct packed {
        logic       present;
        logic [7:0] phys_id;
        logic [7:0] log_byte;
        logic [3:0] model;
    } unit_entry_t;

endpackage

// File: rtl/ird_unit_table.sv
// Module: per-unit table of addressing attributes, one write port,
// all entries visible in parallel. Assumes N_UNITS >= 2.
module ird_unit_table
    import irq_dest_pkg::*;
#(
    parameter int N_UNITS = 8,
    localparam int IDX_W = $clog2(N_UNITS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [IDX_W-1:0]          widx,
    input  unit_entry_t               wentry,
    output unit_entry_t [N_UNITS-1:0] entries
);

    unit_entry_t [N_UNITS-1:0] tbl_q;

    // Table storage: cleared on reset, one entry replaced per write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else if (we && (int'(widx) < N_UNITS)) begin
            tbl_q[widx] <= wentry;
        end
    end

    assign entries = tbl_q;

    // R12: a write lands in the addressed entry
    p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (int'(widx) < N_UNITS)) |=> (entries[$past(widx)] == $past(wentry)));

endmodule

// File: rtl/ird_unit_match.sv
// Module: decides whether one unit matches the destination byte in
// physical or logical mode. Pure combinational; ignores shorthand.
module ird_unit_match
    import irq_dest_pkg::*;
(
    input  unit_entry_t entry,
    input  logic [7:0]  dest,
    input  logic        logical,
    output logic        hit
);

    logic flat_hit;
    logic clus_hit;
    logic phys_hit;

    // Per-mode compares against this unit's attributes.
    always_comb begin
        phys_hit = (dest == BCAST_ID) || (dest == entry.phys_id);
        flat_hit = (entry.model == MODEL_FLAT) && ((dest & entry.log_byte) != 8'h00);
        clus_hit = (entry.model == MODEL_CLUSTER)
                && (dest[7:4] == entry.log_byte[7:4])
                && ((dest[3:0] & entry.log_byte[3:0]) != 4'h0);
        hit = entry.present && (logical ? (flat_hit || clus_hit) : phys_hit);
    end

endmodule

// File: rtl/ird_lowest_pick.sv
// Module: finds the lowest-indexed set bit of a mask.
// idx is 0 when the mask is empty; any reports a nonempty mask.
module ird_lowest_pick #(
    parameter int N_UNITS = 8,
    localparam int IDX_W = $clog2(N_UNITS)
) (
    input  logic [N_UNITS-1:0] mask,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    // Priority scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N_UNITS - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
        any = |mask;
    end

endmodule

// File: rtl/irq_dest_resolver.sv
// Module: top of the destination resolver. Registers the request,
// resolves the target mask combinationally from the registered fields
// and the unit table, and picks a lowest-priority target.
// Assumes N_UNITS >= 2; the result belongs to the cycle after capture.
module irq_dest_resolver
    import irq_dest_pkg::*;
#(
    parameter int N_UNITS = 8,
    localparam int IDX_W = $clog2(N_UNITS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tbl_we,
    input  logic [IDX_W-1:0]   tbl_idx,
    input  logic               tbl_present,
    input  logic [7:0]         tbl_phys_id,
    input  logic [7:0]         tbl_log_byte,
    input  logic [3:0]         tbl_model,
    input  logic               req_valid,
    input  logic [7:0]         req_dest,
    input  logic               req_logical,
    input  logic [1:0]         req_short,
    input  logic [IDX_W-1:0]   req_self,
    input  logic               req_lowpri,
    output logic               res_valid,
    output logic [N_UNITS-1:0] tgt_mask,
    output logic               one_valid,
    output logic [IDX_W-1:0]   one_idx
);

    unit_entry_t [N_UNITS-1:0] entries;
    unit_entry_t               wentry;
    logic [N_UNITS-1:0]        field_mask;
    logic [N_UNITS-1:0]        present_vec;
    logic [N_UNITS-1:0]        self_oh;
    logic                      pick_any;

    logic [7:0]       dest_q;
    logic             logical_q;
    shorthand_e       short_q;
    logic [IDX_W-1:0] self_q;
    logic             lowpri_q;
    logic             valid_q;

    assign wentry = '{present: tbl_present, phys_id: tbl_phys_id,
                      log_byte: tbl_log_byte, model: tbl_model};

    ird_unit_table #(.N_UNITS(N_UNITS)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (tbl_we),
        .widx    (tbl_idx),
        .wentry  (wentry),
        .entries (entries)
    );

    // One matcher per unit.
    generate
        for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
            ird_unit_match u_match (
                .entry   (entries[u]),
                .dest    (dest_q),
                .logical (logical_q),
                .hit     (field_mask[u])
            );
            assign present_vec[u] = entries[u].present;
        end
    endgenerate

    // Request capture register; fields hold until the next request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dest_q    <= '0;
            logical_q <= 1'b0;
            short_q   <= SH_FIELDS;
            self_q    <= '0;
            lowpri_q  <= 1'b0;
            valid_q   <= 1'b0;
        end else begin
            valid_q <= req_valid;
            if (req_valid) begin
                dest_q    <= req_dest;
                logical_q <= req_logical;
                short_q   <= shorthand_e'(req_short);
                self_q    <= req_self;
                lowpri_q  <= req_lowpri;
            end
        end
    end

    // Shorthand selection, restricted to present units.
    always_comb begin
        self_oh = N_UNITS'(1) << self_q;
        unique case (short_q)
            SH_FIELDS:  tgt_mask = field_mask;
            SH_SELF:    tgt_mask = self_oh & present_vec;
            SH_ALL:     tgt_mask = present_vec;
            SH_ALL_BUT: tgt_mask = ~self_oh & present_vec;
            default:    tgt_mask = '0;
        endcase
    end

    ird_lowest_pick #(.N_UNITS(N_UNITS)) u_pick (
        .mask (tgt_mask),
        .any  (pick_any),
        .idx  (one_idx)
    );

    assign res_valid = valid_q;
    assign one_valid = valid_q && lowpri_q && pick_any;

    // R2: result strobe follows a request by one cycle
    p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);
    // R2: no strobe without a request
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid);
    // R10: absent units never appear in the result
    p_absent_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> ((tgt_mask & ~present_vec) == '0));
    // R8: self shorthand names at most one unit
    p_self_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && short_q == SH_SELF) |-> ($countones(tgt_mask) <= 1));
    // R9: all-but-self never names the sender
    p_excl_sender_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && short_q == SH_ALL_BUT) |-> !tgt_mask[self_q]);
    // R11: the single target is a selected unit with nothing lower selected
    p_pick_lowest_r11: assert property (@(posedge clk) disable iff (!rst_n)
        one_valid |-> (tgt_mask[one_idx] &&
                       ((tgt_mask & ((N_UNITS'(1) << one_idx) - N_UNITS'(1))) == '0)));

endmodule

// File: tb/irq_dest_resolver_bench.sv
module irq_dest_resolver_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N = 8;
    localparam int NV = 17;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tbl_we = 1'b0;
    logic [2:0] tbl_idx = '0;
    logic       tbl_present = 1'b0;
    logic [7:0] tbl_phys_id = '0;
    logic [7:0] tbl_log_byte = '0;
    logic [3:0] tbl_model = '0;
    logic       req_valid = 1'b0;
    logic [7:0] req_dest = '0;
    logic       req_logical = 1'b0;
    logic [1:0] req_short = '0;
    logic [2:0] req_self = '0;
    logic       req_lowpri = 1'b0;
    logic       res_valid;
    logic [N-1:0] tgt_mask;
    logic       one_valid;
    logic [2:0] one_idx;

    int checks = 0;
    int errors = 0;

    irq_dest_resolver #(.N_UNITS(N)) u_irq_dest_resolver (
        .clk(clk), .rst_n(rst_n),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_present(tbl_present),
        .tbl_phys_id(tbl_phys_id), .tbl_log_byte(tbl_log_byte), .tbl_model(tbl_model),
        .req_valid(req_valid), .req_dest(req_dest), .req_logical(req_logical),
        .req_short(req_short), .req_self(req_self), .req_lowpri(req_lowpri),
        .res_valid(res_valid), .tgt_mask(tgt_mask),
        .one_valid(one_valid), .one_idx(one_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Vector: {dest, logical, short, self, lowpri, exp_mask, exp_one_valid, exp_one_idx}
    // Table: u0 id10 lb01 F | u1 id11 lb02 F | u2 id12 lb21 0 | u3 id13 lb22 0
    //        u4 id14 lb31 0 | u5 id11 lb04 5 | u6 absent | u7 id17 lb80 F
    localparam logic [26:0] VEC [NV] = '{
        {8'hFF,1'b0,2'd0,3'd0,1'b0, 8'hBF,1'b0,3'd0}, // R3 broadcast
        {8'h13,1'b0,2'd0,3'd0,1'b0, 8'h08,1'b0,3'd0}, // R4 single ID
        {8'h11,1'b0,2'd0,3'd0,1'b0, 8'h22,1'b0,3'd0}, // R4 duplicate ID
        {8'h16,1'b0,2'd0,3'd0,1'b1, 8'h00,1'b0,3'd0}, // R10 R11 absent unit, empty pick
        {8'h55,1'b0,2'd0,3'd0,1'b0, 8'h00,1'b0,3'd0}, // R4 no match
        {8'h03,1'b1,2'd0,3'd0,1'b0, 8'h03,1'b0,3'd0}, // R5 flat
        {8'h84,1'b1,2'd0,3'd0,1'b1, 8'h80,1'b1,3'd7}, // R7 unknown model skipped, R11
        {8'h23,1'b1,2'd0,3'd0,1'b1, 8'h0F,1'b1,3'd0}, // R6 cluster plus flat, R11
        {8'h31,1'b1,2'd0,3'd0,1'b0, 8'h11,1'b0,3'd0}, // R6 other cluster
        {8'h30,1'b1,2'd0,3'd0,1'b0, 8'h00,1'b0,3'd0}, // R6 zero member bits
        {8'hFF,1'b1,2'd0,3'd0,1'b0, 8'h83,1'b0,3'd0}, // R5 all flat bits
        {8'h22,1'b1,2'd0,3'd0,1'b1, 8'h0A,1'b1,3'd1}, // R11 pick index 1
        {8'hFF,1'b1,2'd1,3'd3,1'b0, 8'h08,1'b0,3'd0}, // R8 self, fields ignored
        {8'h00,1'b0,2'd1,3'd6,1'b0, 8'h00,1'b0,3'd0}, // R8 R10 absent self
        {8'h00,1'b0,2'd2,3'd5,1'b0, 8'hBF,1'b0,3'd0}, // R9 all
        {8'h00,1'b0,2'd3,3'd0,1'b1, 8'hBE,1'b1,3'd1}, // R9 all but self, R11
        {8'h00,1'b1,2'd3,3'd6,1'b0, 8'hBF,1'b0,3'd0}  // R9 absent sender
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] i, input logic p, input logic [7:0] id,
                      input logic [7:0] lb, input logic [3:0] m);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = i; tbl_present = p;
        tbl_phys_id = id; tbl_log_byte = lb; tbl_model = m;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // Drives a request, returns at the negedge after the capture edge.
    task automatic rq(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                      input logic [2:0] sf, input logic lp);
        @(negedge clk);
        req_valid = 1'b1; req_dest = d; req_logical = lg;
        req_short = sh; req_self = sf; req_lowpri = lp;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 res_valid in reset", 32'(res_valid), 32'd0);
        chk("R1 one_valid in reset", 32'(one_valid), 32'd0);
        rst_n = 1'b1;
        rq(8'h00, 1'b0, 2'd2, 3'd0, 1'b1);
        chk("R1 empty table mask", 32'(tgt_mask), 32'd0);
        chk("R1 empty table pick", 32'(one_valid), 32'd0);

        wr(3'd0, 1'b1, 8'h10, 8'h01, 4'hF);
        wr(3'd1, 1'b1, 8'h11, 8'h02, 4'hF);
        wr(3'd2, 1'b1, 8'h12, 8'h21, 4'h0);
        wr(3'd3, 1'b1, 8'h13, 8'h22, 4'h0);
        wr(3'd4, 1'b1, 8'h14, 8'h31, 4'h0);
        wr(3'd5, 1'b1, 8'h11, 8'h04, 4'h5);
        wr(3'd6, 1'b0, 8'h16, 8'hFF, 4'hF);
        wr(3'd7, 1'b1, 8'h17, 8'h80, 4'hF);

        for (int v = 0; v < NV; v++) begin
            rq(VEC[v][26:19], VEC[v][18], VEC[v][17:16], VEC[v][15:13], VEC[v][12]);
            chk($sformatf("vector %0d res_valid", v), 32'(res_valid), 32'd1);
            chk($sformatf("vector %0d mask", v), 32'(tgt_mask), 32'(VEC[v][11:4]));
            chk($sformatf("vector %0d one_valid", v), 32'(one_valid), 32'(VEC[v][3]));
            if (VEC[v][3])
                chk($sformatf("vector %0d one_idx", v), 32'(one_idx), 32'(VEC[v][2:0]));
        end

        // R2: strobe timing and hold of captured fields
        @(negedge clk);
        req_valid = 1'b1; req_dest = 8'h13; req_logical = 1'b0;
        req_short = 2'd0; req_lowpri = 1'b0;
        chk("R2 no strobe before capture", 32'(res_valid), 32'd0);
        @(negedge clk);
        req_valid = 1'b0; req_dest = 8'hFF;
        chk("R2 strobe after capture", 32'(res_valid), 32'd1);
        chk("R2 mask holds captured dest", 32'(tgt_mask), 32'h08);
        @(negedge clk);
        chk("R2 strobe lasts one cycle", 32'(res_valid), 32'd0);
        chk("R2 mask unchanged without request", 32'(tgt_mask), 32'h08);

        // R12: table rewrites take effect
        wr(3'd5, 1'b1, 8'h11, 8'h04, 4'hF);
        rq(8'h04, 1'b1, 2'd0, 3'd0, 1'b0);
        chk("R12 rewritten model now flat", 32'(tgt_mask), 32'h20);
        wr(3'd6, 1'b1, 8'h16, 8'hFF, 4'hF);
        rq(8'h16, 1'b0, 2'd0, 3'd0, 1'b1);
        chk("R12 unit made present", 32'(tgt_mask), 32'h40);
        chk("R12 pick of new unit", 32'(one_idx), 32'd6);
        rq(8'h00, 1'b0, 2'd1, 3'd6, 1'b0);
        chk("R8 self now present", 32'(tgt_mask), 32'h40);

        // R1: reset clears the table again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rq(8'hFF, 1'b0, 2'd0, 3'd0, 1'b0);
        chk("R1 table cleared by reset", 32'(tgt_mask), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule